// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog that software must service within a programmable window. A down-counter is reloaded by a two-write unlock on a byte-wide service register. It decrements on enabled counting clocks, which can be divided by an optional prescaler. If the counter runs past zero, or the service sequence is malformed or lands outside the allowed window, the block sets a sticky status flag. The active flag drives either an interrupt request or a reset request.

Configuration is deliberately hard to disturb. The control word and the action-select register each take one write, and only between reset release and the first completed service sequence. After that they hold their values until the next reset. The counting clock reaches the block as a clock-enable pulse, so the block runs entirely in the bus clock domain.

Top module: `wwdt_core`

## Requirements
- R1: After reset the status register (offset 4) reads zero, the control register (offset 2) reads the parameter CTRL_RST, the action register (offset 6) reads zero, and both request outputs are low. Status bit 0 is the underflow flag, bit 1 is the service-error flag, and bits [15:2] hold the counter value.
- R2: The counter holds its value (zero after reset) until a write of 0x00 to the service register (offset 0) is directly followed by a write of 0xFF to the same register. That sequence loads the reload value and starts counting.
- R3: Control bits [1:0] choose the reload value. Codes 0, 1, 2 and 3 give 2^B-1, 2^(B+2)-1, 2^(B+3)-1 and 2^(B+4)-1, where B is BASE_LOG2. Each counting tick while running lowers the count by one. A tick at count zero sets the underflow flag and reloads the counter.
- R4: When control bits [7:4] equal 0101, one tick occurs every 2^DIV_LOG2 enabled counting clocks, and the prescaler restarts at each valid service. Every other code gives one tick per enabled counting clock.
- R5: While running, a completed sequence is valid only when count <= S and count > E. S is 1/4 of 2^L for start code 0, 2/4 for codes 1 and 2, and 4/4 for code 3 (bits [13:12]). E is 3/4, 2/4, 1/4 and 0 of 2^L for end codes 0 to 3 (bits [9:8]). L is the log2 of the selected period.
- R6: A completed sequence outside the window, or a 0x00 write followed by a service write other than 0xFF, sets the service-error flag and leaves the counter unchanged.
- R7: The control register and the action register each accept only the first write after reset, and only while the counter has not yet started. Any later write leaves the read value unchanged.
- R8: Writing the status register clears each flag whose data bit is 0. A flag whose data bit is 1 keeps its value.
- R9: Action bit 7 = 0 drives irq_req while either flag is set. Bit 7 = 1 drives rst_req instead. The two outputs are never high together.
- R10: A service write of 0xFF with no 0x00 before it, or of any other value except 0x00, is ignored. It leaves flags and count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Counting clock enable pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write byte offset (0, 2, 4, 6) |
| wr_data | input | 16 | Write data; byte registers use [7:0] |
| rd_addr | input | 3 | Read byte offset |
| rd_data | output | 16 | Read data for rd_addr |
| irq_req | output | 1 | Interrupt request level |
| rst_req | output | 1 | Reset request level |

## Verification
The bench builds the block with BASE_LOG2 = 2 and DIV_LOG2 = 2. This makes the four reload values 3, 15, 31 and 63, and the prescaler divides by 4. Every period can therefore be counted to underflow in a few dozen cycles. The bench sweeps all sixteen window start/end code pairs against every count from 0 to 63, with the expected validity computed from the quarter thresholds. This covers each threshold edge exactly.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;

   localparam logic [2:0] OFS_SVC  = 3'd0;
   localparam logic [2:0] OFS_CTRL = 3'd2;
   localparam logic [2:0] OFS_STAT = 3'd4;
   localparam logic [2:0] OFS_ACT  = 3'd6;

   typedef struct packed {
      logic [1:0] rsv_hi;
      logic [1:0] win_start;
      logic [1:0] rsv_mid;
      logic [1:0] win_end;
      logic [3:0] div_sel;
      logic [1:0] rsv_lo;
      logic [1:0] tsel;
   } wwdt_ctrl_t;

   localparam logic [3:0] DIV_ON_CODE = 4'b0101;

   function automatic int unsigned period_log2(input logic [1:0] code,
                                               input int unsigned base);
      case (code)
         2'd0:    return base;
         2'd1:    return base + 2;
         2'd2:    return base + 3;
         default: return base + 4;
      endcase
   endfunction

endpackage

// File: rtl/wwdt_presc.sv
module wwdt_presc #(
   parameter int unsigned DIV_LOG2 = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   input  logic div_on,
   output logic tick
);
   if (DIV_LOG2 == 0) begin : g_nodiv
      assign tick = en;
   end else begin : g_div
      logic [DIV_LOG2-1:0] pc;

      always_ff @(posedge clk) begin
         if (!rst_n || clr || !div_on) pc <= '0;
         else if (en)                  pc <= pc + 1'b1;
      end

      assign tick = en && (!div_on || (&pc));

      AST_PC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
         (!div_on) |=> (pc == '0)); // R4
   end
endmodule

// File: rtl/wwdt_window.sv
module wwdt_window
   import wwdt_pkg::*;
#(
   parameter int unsigned BASE_LOG2 = 10,
   localparam int unsigned CNT_W = BASE_LOG2 + 4
) (
   input  logic [1:0]       tsel,
   input  logic [1:0]       win_start,
   input  logic [1:0]       win_end,
   input  logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] reload,
   output logic             in_win
);
   localparam logic [CNT_W:0] ONE = 1;

   int unsigned   lg;
   logic [CNT_W:0] span, qtr, s_th, e_th, cnt_x;

   always_comb begin
      lg    = period_log2(tsel, BASE_LOG2);
      span  = ONE << lg;
      qtr   = span >> 2;
      reload = CNT_W'(span - ONE);
      case (win_start)
         2'd0:    s_th = qtr;
         2'd1,
         2'd2:    s_th = qtr << 1;
         default: s_th = span;
      endcase
      case (win_end)
         2'd0:    e_th = (qtr << 1) + qtr;
         2'd1:    e_th = qtr << 1;
         2'd2:    e_th = qtr;
         default: e_th = '0;
      endcase
      cnt_x  = {1'b0, cnt};
      in_win = (cnt_x <= s_th) && (cnt_x > e_th);
   end
endmodule

// File: rtl/wwdt_core.sv
module wwdt_core
   import wwdt_pkg::*;
#(
   parameter int unsigned BASE_LOG2 = 10,
   parameter int unsigned DIV_LOG2  = 8,
   parameter logic [15:0] CTRL_RST  = 16'h3303
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cnt_en,
   input  logic        wr_en,
   input  logic [2:0]  wr_addr,
   input  logic [15:0] wr_data,
   input  logic [2:0]  rd_addr,
   output logic [15:0] rd_data,
   output logic        irq_req,
   output logic        rst_req
);
   localparam int unsigned CNT_W = BASE_LOG2 + 4;
   localparam logic [CNT_W-1:0] CNT_ONE = 1;

   if (BASE_LOG2 < 2 || BASE_LOG2 > 10) begin : g_bad_base
      $error("wwdt_core: BASE_LOG2 must lie in 2..10");
   end
   if (DIV_LOG2 > 16) begin : g_bad_div
      $error("wwdt_core: DIV_LOG2 must not exceed 16");
   end

   wwdt_ctrl_t       ctrl_q;
   logic             ctrl_done, act_done, act_rst;
   logic             running, armed, sts_uf, sts_re;
   logic [CNT_W-1:0] cnt, reload;
   logic             in_win, tick;

   logic wr_svc, seq_ok, seq_bad, svc_good, err_evt, uf_evt;
   logic wr_ctrl, wr_act, wr_stat;

   assign wr_svc   = wr_en && (wr_addr == OFS_SVC);
   assign wr_ctrl  = wr_en && (wr_addr == OFS_CTRL) && !running && !ctrl_done;
   assign wr_act   = wr_en && (wr_addr == OFS_ACT)  && !running && !act_done;
   assign wr_stat  = wr_en && (wr_addr == OFS_STAT);
   assign seq_ok   = wr_svc && armed && (wr_data[7:0] == 8'hFF);
   assign seq_bad  = wr_svc && armed && (wr_data[7:0] != 8'hFF);
   assign svc_good = seq_ok && (!running || in_win);
   assign err_evt  = seq_bad || (seq_ok && running && !in_win);
   assign uf_evt   = running && tick && (cnt == '0) && !svc_good;

   wwdt_window #(.BASE_LOG2(BASE_LOG2)) u_win (
      .tsel      (ctrl_q.tsel),
      .win_start (ctrl_q.win_start),
      .win_end   (ctrl_q.win_end),
      .cnt       (cnt),
      .reload    (reload),
      .in_win    (in_win)
   );

   wwdt_presc #(.DIV_LOG2(DIV_LOG2)) u_presc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (svc_good),
      .en     (cnt_en && running),
      .div_on (ctrl_q.div_sel == DIV_ON_CODE),
      .tick   (tick)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q    <= wwdt_ctrl_t'(CTRL_RST);
         ctrl_done <= 1'b0;
         act_done  <= 1'b0;
         act_rst   <= 1'b0;
         running   <= 1'b0;
         armed     <= 1'b0;
         sts_uf    <= 1'b0;
         sts_re    <= 1'b0;
         cnt       <= '0;
      end else begin
         if (wr_ctrl) begin
            ctrl_q    <= wwdt_ctrl_t'(wr_data);
            ctrl_done <= 1'b1;
         end
         if (wr_act) begin
            act_rst  <= wr_data[7];
            act_done <= 1'b1;
         end
         if (wr_svc) armed <= !armed && (wr_data[7:0] == 8'h00);
         if (svc_good) running <= 1'b1;

         sts_uf <= (sts_uf && !(wr_stat && !wr_data[0])) || uf_evt;
         sts_re <= (sts_re && !(wr_stat && !wr_data[1])) || err_evt;

         if (svc_good)              cnt <= reload;
         else if (running && tick)  cnt <= (cnt == '0) ? reload : cnt - CNT_ONE;
      end
   end

   always_comb begin
      case (rd_addr)
         OFS_CTRL: rd_data = ctrl_q;
         OFS_STAT: rd_data = {14'(cnt), sts_re, sts_uf};
         OFS_ACT:  rd_data = {8'h00, act_rst, 7'h00};
         default:  rd_data = 16'h0000;
      endcase
   end

   assign irq_req = (sts_uf || sts_re) && !act_rst;
   assign rst_req = (sts_uf || sts_re) &&  act_rst;

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !svc_good) |=> $stable(cnt)); // R2
   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= reload); // R3
   AST_ERR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      err_evt |=> sts_re); // R6
   AST_ERR_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (err_evt && !(running && tick)) |=> $stable(cnt)); // R6
   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      running |=> ($stable(ctrl_q) && $stable(act_rst))); // R7
   AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq_req && rst_req)); // R9
endmodule

// File: tb/sim_wwdt_core.sv
`timescale 1ns/1ps
module sim_wwdt_core;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cnt_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = 3'd0;
   logic [15:0] wr_data = 16'h0;
   logic [2:0]  rd_addr = 3'd0;
   logic [15:0] rd_data;
   logic        irq_req, rst_req;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   wwdt_core #(.BASE_LOG2(2), .DIV_LOG2(2), .CTRL_RST(16'h3303)) u0 (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .irq_req(irq_req), .rst_req(rst_req));

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      rd_addr = a; #1; d = rd_data;
   endtask

   task automatic ticks(input int n);
      if (n > 0) begin
         @(negedge clk); cnt_en = 1'b1;
         repeat (n) @(negedge clk);
         cnt_en = 1'b0;
      end
   endtask

   task automatic service();
      wr(3'd0, 16'h0000); wr(3'd0, 16'h00FF);
   endtask

   initial begin
      #1500000;
      errors++;
      $display("FAIL watchdog timeout actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] v;
      do_reset();
      @(negedge clk);
      rd(3'd4, v); check("R1 status reset", v, 0);
      rd(3'd2, v); check("R1 ctrl reset", v, 16'h3303);
      rd(3'd6, v); check("R1 act reset", v, 0);
      check("R1 irq reset", irq_req, 0);
      check("R1 rst reset", rst_req, 0);

      ticks(5);
      rd(3'd4, v); check("R2 no count before start", v, 0);
      service();
      rd(3'd4, v); check("R2 start loads reload", v >> 2, 63);

      // R3: each period to underflow
      for (int t = 0; t < 4; t++) begin
         int r;
         r = (t == 0) ? 3 : (t == 1) ? 15 : (t == 2) ? 31 : 63;
         do_reset();
         wr(3'd2, 16'h3300 | 16'(t));
         service();
         rd(3'd4, v); check("R3 reload", v >> 2, r);
         ticks(r);
         rd(3'd4, v); check("R3 at zero", v, 0);
         check("R3 no irq yet", irq_req, 0);
         ticks(1);
         rd(3'd4, v); check("R3 underflow reload", v >> 2, r);
         check("R3 uf flag", v & 3, 1);
         check("R9 irq on uf", irq_req, 1);
      end

      // R4 prescaler
      do_reset();
      wr(3'd2, 16'h3350);
      service();
      ticks(3);
      rd(3'd4, v); check("R4 div hold", v >> 2, 3);
      ticks(1);
      rd(3'd4, v); check("R4 div step", v >> 2, 2);
      ticks(8);
      rd(3'd4, v); check("R4 div two more", v >> 2, 0);
      do_reset();
      wr(3'd2, 16'h3330);
      service();
      ticks(1);
      rd(3'd4, v); check("R4 other code div1", v >> 2, 2);

      // R7 write-once
      do_reset();
      wr(3'd2, 16'h3301); wr(3'd2, 16'h3303);
      rd(3'd2, v); check("R7 ctrl second write", v, 16'h3301);
      wr(3'd6, 16'h0080); wr(3'd6, 16'h0000);
      rd(3'd6, v); check("R7 act second write", v, 16'h0080);
      do_reset();
      service();
      wr(3'd2, 16'h0000);
      rd(3'd2, v); check("R7 ctrl after start", v, 16'h3303);
      wr(3'd6, 16'h0080);
      rd(3'd6, v); check("R7 act after start", v, 0);

      // R10 lone writes, R6 broken sequence, R8 clear, R9 reset action
      do_reset();
      wr(3'd6, 16'h0080);
      service();
      ticks(2);
      wr(3'd0, 16'h00FF);
      wr(3'd0, 16'h0012);
      rd(3'd4, v); check("R10 lone writes ignored", v, 61 << 2);
      wr(3'd0, 16'h0000); wr(3'd0, 16'h0055);
      rd(3'd4, v); check("R6 broken seq flag+hold", v, (61 << 2) | 2);
      check("R9 rst_req", rst_req, 1);
      check("R9 irq off", irq_req, 0);
      wr(3'd4, 16'h0002);
      rd(3'd4, v); check("R8 write one keeps", v & 3, 2);
      wr(3'd4, 16'h0000);
      rd(3'd4, v); check("R8 write zero clears", v & 3, 0);
      check("R8 rst_req drops", rst_req, 0);

      // R5/R6 window sweep, period code 3 (reload 63, quarter 16)
      for (int s = 0; s < 4; s++) begin
         for (int e = 0; e < 4; e++) begin
            int sth, eth;
            sth = (s == 0) ? 16 : (s == 3) ? 64 : 32;
            eth = (e == 0) ? 48 : (e == 1) ? 32 : (e == 2) ? 16 : 0;
            for (int c = 0; c < 64; c++) begin
               bit ok;
               do_reset();
               wr(3'd2, 16'((s << 12) | (e << 8) | 3));
               service();
               ticks(63 - c);
               service();
               ok = (c <= sth) && (c > eth);
               rd(3'd4, v);
               if (ok) check("R5 valid service reload", v, 63 << 2);
               else    check("R6 invalid service", v, (c << 2) | 2);
            end
         end
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule